// File: doc/BRIEF.md
# Memory Operation Ordering Dispatcher

This block sits at the dispatch point of an out-of-order core and admits memory operations one at a time. For each candidate operation it reports whether the load queue or store queue has room. It also assigns the operation a dependency group token. It emits up to three dependency edges, from older groups to the new group, for a separate group tracker to record. Each operation is described by three flags: may-load, may-store and side-effects. An operation with the side-effects flag is treated as a barrier. With the load flag it is a load barrier, with the store flag a store barrier, and with both flags a full barrier.

Queue occupancy is counted inside the block. Loads give back their entry at retirement and stores at commit. When the tracker reports that a group has finished executing, the block drops any reference to that group, so later operations no longer wait on it. Loads may run ahead of older stores only when the no-alias parameter is set.

Top module: `memq_dispatch`

## Requirements
- R1: After reset both used counts are zero, both empty flags are 1, both full flags are 0, and the first accepted memory operation gets group 1 with no edges.
- R2: `status` is 0 (available), 1 (load queue full) or 2 (store queue full). It is 1 when a valid operation with the load flag meets a full load queue. Otherwise it is 2 when a valid operation with the store flag meets a full store queue. An operation with neither flag always sees 0.
- R3: `accept` is 1 only for a valid operation that has at least one of the load and store flags and whose status is 0. A rejected operation changes no count, no group register and no group numbering.
- R4: An accepted operation takes one entry in the load queue if it has the load flag, and one in the store queue if it has the store flag. A `ld_retire` pulse frees one load entry and a `st_commit` pulse frees one store entry. An allocation and a release in the same cycle leave the count unchanged. A release at a count of zero is ignored.
- R5: A queue is full when its depth parameter is nonzero and its count equals the depth. A depth of zero never reports full. A queue is empty when its count is zero.
- R6: A plain load (load flag only) joins the current load group, with the same group ID and no edges, if that group is still open. Any store (unless no-alias is set) or any load barrier closes the group.
- R7: An operation with the store flag always opens a new group. It takes an edge from the current load group (slot 0) and from the current store group (slot 1), when those exist.
- R8: An operation with the load flag takes a slot-1 edge from the current store group only when NO_ALIAS is 0. When NO_ALIAS is 1, a plain store neither adds that edge nor closes the open load group.
- R9: An operation with load and side-effects flags becomes the current load barrier group and takes a slot-0 edge from the current load group. Every later operation with the load flag takes a slot-2 edge from the current load barrier group. A full barrier takes all three edges.
- R10: An `exe_valid` pulse naming the current load, store or load barrier group removes that group. Operations after it get no edge from it.
- R11: Each new group gets the next ID, starting at 1, counting up by one and never 0. An operation with neither load nor store flag reports group 0.
- R12: `edge_valid` is zero unless `accept` is 1. Slot 1 is dropped when it would name the same group as slot 0. Slot 2 is dropped when it would name the same group as slot 0 or slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A candidate operation is presented |
| op_ld | input | 1 | Operation may load |
| op_st | input | 1 | Operation may store |
| op_fx | input | 1 | Operation has side effects (barrier) |
| ld_retire | input | 1 | One load leaves the load queue |
| st_commit | input | 1 | One store leaves the store queue |
| exe_valid | input | 1 | A group has fully executed |
| exe_gid | input | GID_W | ID of the executed group |
| status | output | 2 | 0 available, 1 load queue full, 2 store queue full |
| accept | output | 1 | Operation is dispatched this cycle |
| gid | output | GID_W | Group assigned to the operation |
| edge_valid | output | 3 | Edge slots: 0 load group, 1 store group, 2 load barrier group |
| edge_src | output | 3*GID_W | Source group of each slot, slot k at bits k*GID_W |
| lq_used | output | CNT_W | Load queue entries in use |
| sq_used | output | CNT_W | Store queue entries in use |
| lq_full | output | 1 | Load queue full |
| sq_full | output | 1 | Store queue full |
| lq_empty | output | 1 | Load queue empty |
| sq_empty | output | 1 | Store queue empty |

## Verification
The hardest case to reach is one operation that draws three distinct edges at once. That needs an uncleared load barrier, a newer load group and a newer store group all present together, and both queues must also have room. The stimulus builds this case on purpose. A load barrier is left unexecuted while a store and a load are admitted after it. Both queues are then drained through retire and commit pulses, and finally a full barrier is presented. The cleared-by-execution case is reached by reporting the current load and store groups as executed before a store, which must then come out with no edges at all.

// File: rtl/mqd_pkg.sv
package mqd_pkg;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_LQ_FULL = 2'd1,
        ST_SQ_FULL = 2'd2
    } disp_status_e;

    localparam int unsigned NUM_EDGES = 3;
    localparam int unsigned EDGE_LD   = 0;
    localparam int unsigned EDGE_ST   = 1;
    localparam int unsigned EDGE_LB   = 2;

    typedef struct packed {
        logic is_mem;
        logic uses_lq;
        logic uses_sq;
        logic ld_bar;
        logic plain_ld;
    } op_class_t;

    function automatic op_class_t classify(input logic ld, input logic st, input logic fx);
        op_class_t c;
        c.is_mem   = ld | st;
        c.uses_lq  = ld;
        c.uses_sq  = st;
        c.ld_bar   = ld & fx;
        c.plain_ld = ld & ~st & ~fx;
        return c;
    endfunction

endpackage

// File: rtl/mqd_occupancy.sv
module mqd_occupancy #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic             free,
    output logic [CNT_W-1:0] used,
    output logic             full,
    output logic             empty
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic do_inc, do_dec, at_cap;

    generate
        if (DEPTH == 0) begin : g_unbounded
            assign full   = 1'b0;
            assign at_cap = (used == CNT_MAX);
        end else begin : g_bounded
            localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH);
            assign full   = (used == LIMIT);
            assign at_cap = full;
        end
    endgenerate

    assign empty  = (used == '0);
    assign do_inc = alloc & ~at_cap;
    assign do_dec = free & ~empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            used <= '0;
        end else if (do_inc && !do_dec) begin
            used <= used + 1'b1;
        end else if (do_dec && !do_inc) begin
            used <= used - 1'b1;
        end
    end
endmodule

// File: rtl/mqd_gid_alloc.sv
module mqd_gid_alloc #(
    parameter int unsigned GID_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [GID_W-1:0] next_gid
);
    localparam logic [GID_W-1:0] GID_FIRST = GID_W'(1);
    localparam logic [GID_W-1:0] GID_LAST  = {GID_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            next_gid <= GID_FIRST;
        end else if (bump) begin
            next_gid <= (next_gid == GID_LAST) ? GID_FIRST : next_gid + 1'b1;
        end
    end
endmodule

// File: rtl/mqd_order_rules.sv
module mqd_order_rules
    import mqd_pkg::*;
#(
    parameter int unsigned GID_W    = 6,
    parameter bit          NO_ALIAS = 1'b0,
    localparam int unsigned EW      = NUM_EDGES * GID_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  op_class_t            cls,
    input  logic                 accept,
    input  logic [GID_W-1:0]     next_gid,
    input  logic                 exe_valid,
    input  logic [GID_W-1:0]     exe_gid,
    output logic [GID_W-1:0]     gid,
    output logic                 new_grp,
    output logic [NUM_EDGES-1:0] edge_valid,
    output logic [EW-1:0]        edge_src
);
    typedef struct packed {
        logic             vld;
        logic [GID_W-1:0] id;
    } grp_ref_t;

    grp_ref_t cur_ld, cur_st, cur_lb;
    logic     ld_open;

    logic join_grp, e_ld, e_st_raw, e_st, e_lb;

    always_comb begin
        join_grp = cls.plain_ld & ld_open & cur_ld.vld;
        e_ld     = ~join_grp & cur_ld.vld & (cls.uses_sq | cls.ld_bar);
        e_st_raw = ~join_grp & cur_st.vld & (cls.uses_sq | (cls.uses_lq & ~NO_ALIAS));
        e_st     = e_st_raw & ~(e_ld && (cur_st.id == cur_ld.id));
        e_lb     = ~join_grp & cur_lb.vld & cls.uses_lq
                   & ~(e_ld && (cur_lb.id == cur_ld.id))
                   & ~(e_st_raw && (cur_lb.id == cur_st.id));
        gid      = join_grp ? cur_ld.id : next_gid;
        new_grp  = ~join_grp;

        edge_valid                      = '0;
        edge_valid[EDGE_LD]             = accept & e_ld;
        edge_valid[EDGE_ST]             = accept & e_st;
        edge_valid[EDGE_LB]             = accept & e_lb;
        edge_src                        = '0;
        edge_src[EDGE_LD*GID_W +: GID_W] = cur_ld.id;
        edge_src[EDGE_ST*GID_W +: GID_W] = cur_st.id;
        edge_src[EDGE_LB*GID_W +: GID_W] = cur_lb.id;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ld  <= '0;
            cur_st  <= '0;
            cur_lb  <= '0;
            ld_open <= 1'b0;
        end else begin
            if (exe_valid) begin
                if (cur_ld.vld && cur_ld.id == exe_gid) cur_ld.vld <= 1'b0;
                if (cur_st.vld && cur_st.id == exe_gid) cur_st.vld <= 1'b0;
                if (cur_lb.vld && cur_lb.id == exe_gid) cur_lb.vld <= 1'b0;
            end
            if (accept) begin
                if (cls.uses_sq) begin
                    cur_st <= '{vld: 1'b1, id: gid};
                    if (!NO_ALIAS) ld_open <= 1'b0;
                end
                if (cls.uses_lq) begin
                    cur_ld  <= '{vld: 1'b1, id: gid};
                    ld_open <= cls.plain_ld;
                end
                if (cls.ld_bar) begin
                    cur_lb <= '{vld: 1'b1, id: gid};
                end
            end
        end
    end
endmodule

// File: rtl/memq_dispatch.sv
module memq_dispatch
    import mqd_pkg::*;
#(
    parameter int unsigned LQ_DEPTH = 4,
    parameter int unsigned SQ_DEPTH = 3,
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned GID_W    = 6,
    parameter bit          NO_ALIAS = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     op_valid,
    input  logic                     op_ld,
    input  logic                     op_st,
    input  logic                     op_fx,
    input  logic                     ld_retire,
    input  logic                     st_commit,
    input  logic                     exe_valid,
    input  logic [GID_W-1:0]         exe_gid,
    output logic [1:0]               status,
    output logic                     accept,
    output logic [GID_W-1:0]         gid,
    output logic [2:0]               edge_valid,
    output logic [3*GID_W-1:0]       edge_src,
    output logic [CNT_W-1:0]         lq_used,
    output logic [CNT_W-1:0]         sq_used,
    output logic                     lq_full,
    output logic                     sq_full,
    output logic                     lq_empty,
    output logic                     sq_empty
);
    op_class_t        cls;
    disp_status_e     stat;
    logic [GID_W-1:0] next_gid, rule_gid;
    logic             new_grp;

    assign cls = classify(op_ld, op_st, op_fx);

    always_comb begin
        stat = ST_OK;
        if (op_valid && cls.uses_lq && lq_full)      stat = ST_LQ_FULL;
        else if (op_valid && cls.uses_sq && sq_full) stat = ST_SQ_FULL;
    end

    assign status = stat;
    assign accept = op_valid & cls.is_mem & (stat == ST_OK);
    assign gid    = cls.is_mem ? rule_gid : '0;

    mqd_occupancy #(.DEPTH(LQ_DEPTH), .CNT_W(CNT_W)) u_lq (
        .clk(clk), .rst(rst), .alloc(accept & cls.uses_lq), .free(ld_retire),
        .used(lq_used), .full(lq_full), .empty(lq_empty)
    );

    mqd_occupancy #(.DEPTH(SQ_DEPTH), .CNT_W(CNT_W)) u_sq (
        .clk(clk), .rst(rst), .alloc(accept & cls.uses_sq), .free(st_commit),
        .used(sq_used), .full(sq_full), .empty(sq_empty)
    );

    mqd_gid_alloc #(.GID_W(GID_W)) u_gid (
        .clk(clk), .rst(rst), .bump(accept & new_grp), .next_gid(next_gid)
    );

    mqd_order_rules #(.GID_W(GID_W), .NO_ALIAS(NO_ALIAS)) u_rules (
        .clk(clk), .rst(rst), .cls(cls), .accept(accept), .next_gid(next_gid),
        .exe_valid(exe_valid), .exe_gid(exe_gid), .gid(rule_gid), .new_grp(new_grp),
        .edge_valid(edge_valid), .edge_src(edge_src)
    );
endmodule

// File: rtl/memq_dispatch_chk.sv
module memq_dispatch_chk #(
    parameter int unsigned LQ_DEPTH = 4,
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned GID_W    = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic             op_ld,
    input logic             op_st,
    input logic [1:0]       status,
    input logic             accept,
    input logic [GID_W-1:0] gid,
    input logic [2:0]       edge_valid,
    input logic [CNT_W-1:0] lq_used,
    input logic             lq_full
);
    a_r2_nonmem_ok: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_ld && !op_st) |-> status == 2'd0);

    a_r2_lq_full_status: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ld && lq_full) |-> status == 2'd1);

    a_r3_accept_ok: assert property (@(posedge clk) disable iff (rst)
        accept |-> (op_valid && status == 2'd0));

    a_r4_lq_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lq_used == $past(lq_used)) ||
                        (lq_used == $past(lq_used) + 1'b1) ||
                        (lq_used + 1'b1 == $past(lq_used)));

    a_r5_lq_bound: assert property (@(posedge clk) disable iff (rst)
        (LQ_DEPTH != 0) |-> (32'(lq_used) <= LQ_DEPTH));

    a_r11_gid_nonzero: assert property (@(posedge clk) disable iff (rst)
        accept |-> gid != '0);

    a_r12_edges_idle: assert property (@(posedge clk) disable iff (rst)
        !accept |-> edge_valid == 3'b000);
endmodule

bind memq_dispatch memq_dispatch_chk #(
    .LQ_DEPTH(LQ_DEPTH), .CNT_W(CNT_W), .GID_W(GID_W)
) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ld(op_ld), .op_st(op_st),
    .status(status), .accept(accept), .gid(gid), .edge_valid(edge_valid),
    .lq_used(lq_used), .lq_full(lq_full)
);

// File: tb/memq_dispatch_bench.sv
`timescale 1ns/1ps
module memq_dispatch_bench;
    localparam int GW = 6;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic op_ld = 0, op_st = 0, op_fx = 0;
    logic [GW-1:0] exe_gid = '0;
    logic va = 0, ra = 0, ca = 0, xa = 0;
    logic vb = 0, rb = 0, cb = 0, xb = 0;

    logic [1:0] st_a, st_b;
    logic acc_a, acc_b, lf_a, lf_b, sf_a, sf_b, le_a, le_b, se_a, se_b;
    logic [GW-1:0] g_a, g_b;
    logic [2:0] ev_a, ev_b;
    logic [3*GW-1:0] es_a, es_b;
    logic [CW-1:0] lu_a, lu_b, su_a, su_b;

    memq_dispatch u_memq_dispatch (
        .clk(clk), .rst(rst), .op_valid(va), .op_ld(op_ld), .op_st(op_st), .op_fx(op_fx),
        .ld_retire(ra), .st_commit(ca), .exe_valid(xa), .exe_gid(exe_gid),
        .status(st_a), .accept(acc_a), .gid(g_a), .edge_valid(ev_a), .edge_src(es_a),
        .lq_used(lu_a), .sq_used(su_a), .lq_full(lf_a), .sq_full(sf_a),
        .lq_empty(le_a), .sq_empty(se_a)
    );

    memq_dispatch #(.LQ_DEPTH(0), .SQ_DEPTH(2), .NO_ALIAS(1'b1)) u_memq_dispatch_alt (
        .clk(clk), .rst(rst), .op_valid(vb), .op_ld(op_ld), .op_st(op_st), .op_fx(op_fx),
        .ld_retire(rb), .st_commit(cb), .exe_valid(xb), .exe_gid(exe_gid),
        .status(st_b), .accept(acc_b), .gid(g_b), .edge_valid(ev_b), .edge_src(es_b),
        .lq_used(lu_b), .sq_used(su_b), .lq_full(lf_b), .sq_full(sf_b),
        .lq_empty(le_b), .sq_empty(se_b)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one operation to A (b=0) or B (b=1); check status, accept, gid, edges.
    task automatic op(input bit b, input bit ld, input bit st, input bit fx,
                      input bit rel_l, input bit rel_s, input string req,
                      input int exp_st, input int exp_acc, input int exp_gid,
                      input int exp_ev, input int s0, input int s1, input int s2);
        logic [2:0] ev;
        logic [3*GW-1:0] es;
        @(negedge clk);
        op_ld = ld; op_st = st; op_fx = fx;
        if (b) begin vb = 1; rb = rel_l; cb = rel_s; end
        else   begin va = 1; ra = rel_l; ca = rel_s; end
        #1;
        ev = b ? ev_b : ev_a;
        es = b ? es_b : es_a;
        check({req, " status"}, int'(b ? st_b : st_a), exp_st);
        check({req, " accept"}, int'(b ? acc_b : acc_a), exp_acc);
        check({req, " gid"}, int'(b ? g_b : g_a), exp_gid);
        check({req, " edges"}, int'(ev), exp_ev);
        if (ev[0]) check({req, " slot0"}, int'(es[0 +: GW]), s0);
        if (ev[1]) check({req, " slot1"}, int'(es[GW +: GW]), s1);
        if (ev[2]) check({req, " slot2"}, int'(es[2*GW +: GW]), s2);
        @(negedge clk);
        va = 0; vb = 0; ra = 0; rb = 0; ca = 0; cb = 0;
        op_ld = 0; op_st = 0; op_fx = 0;
    endtask

    task automatic release_a(input bit l, input bit s);
        @(negedge clk);
        ra = l; ca = s;
        @(negedge clk);
        ra = 0; ca = 0;
    endtask

    task automatic exec_a(input int g);
        @(negedge clk);
        xa = 1; exe_gid = GW'(g);
        @(negedge clk);
        xa = 0;
    endtask

    task automatic counts_a(input string req, input int lq, input int sq);
        #1;
        check({req, " lq_used"}, int'(lu_a), lq);
        check({req, " sq_used"}, int'(su_a), sq);
    endtask

    task automatic t_reset;
        check("R1 lq_used", int'(lu_a), 0);
        check("R1 sq_used", int'(su_a), 0);
        check("R1 lq_empty", int'(le_a), 1);
        check("R1 sq_empty", int'(se_a), 1);
        check("R1 lq_full", int'(lf_a), 0);
        check("R1 sq_full", int'(sf_a), 0);
    endtask

    task automatic t_main_a;
        op(0, 0, 0, 0, 0, 0, "R2 R11 nonmem", 0, 0, 0, 0, 0, 0, 0);
        op(0, 1, 0, 0, 0, 0, "R1 first load", 0, 1, 1, 0, 0, 0, 0);
        op(0, 1, 0, 0, 0, 0, "R6 load joins", 0, 1, 1, 0, 0, 0, 0);
        counts_a("R4 two loads", 2, 0);
        op(0, 0, 1, 0, 0, 0, "R7 store after loads", 0, 1, 2, 3'b001, 1, 0, 0);
        op(0, 1, 0, 0, 0, 0, "R8 load after store", 0, 1, 3, 3'b010, 0, 2, 0);
        op(0, 0, 1, 0, 0, 0, "R7 second store", 0, 1, 4, 3'b011, 3, 2, 0);
        op(0, 1, 0, 1, 0, 0, "R9 load barrier", 0, 1, 5, 3'b011, 3, 4, 0);
        counts_a("R4 R5 lq at depth", 4, 2);
        check("R5 lq_full", int'(lf_a), 1);
        op(0, 1, 0, 0, 0, 0, "R2 R3 lq full", 1, 0, 6, 0, 0, 0, 0);
        counts_a("R3 reject no change", 4, 2);
        release_a(1, 0);
        counts_a("R4 retire", 3, 2);
        op(0, 0, 1, 0, 0, 1, "R11 R3 store after reject", 0, 1, 6, 3'b011, 5, 4, 0);
        counts_a("R4 alloc and commit same cycle", 3, 2);
        op(0, 1, 0, 0, 0, 0, "R9 load behind barrier", 0, 1, 7, 3'b110, 0, 6, 5);
        release_a(1, 0);
        exec_a(7);
        exec_a(6);
        op(0, 0, 1, 0, 0, 0, "R10 store after exec", 0, 1, 8, 0, 0, 0, 0);
        check("R5 sq_full", int'(sf_a), 1);
        op(0, 0, 1, 0, 0, 0, "R2 sq full", 2, 0, 9, 0, 0, 0, 0);
        op(0, 1, 0, 0, 0, 0, "R10 R9 load", 0, 1, 9, 3'b110, 0, 8, 5);
        op(0, 1, 1, 0, 0, 0, "R2 both full priority", 1, 0, 10, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) release_a(1, 0);
        counts_a("R4 release at zero", 0, 3);
        check("R5 lq_empty", int'(le_a), 1);
        for (int i = 0; i < 3; i++) release_a(0, 1);
        counts_a("R4 commits", 0, 0);
        op(0, 1, 1, 1, 0, 0, "R9 full barrier", 0, 1, 10, 3'b111, 9, 8, 5);
        op(0, 1, 0, 0, 0, 0, "R12 slot suppression", 0, 1, 11, 3'b010, 0, 10, 0);
    endtask

    task automatic t_alt_b;
        op(1, 1, 0, 0, 0, 0, "R8 alt load", 0, 1, 1, 0, 0, 0, 0);
        op(1, 0, 1, 0, 0, 0, "R7 alt store", 0, 1, 2, 3'b001, 1, 0, 0);
        op(1, 1, 0, 0, 0, 0, "R8 alt load passes store", 0, 1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++)
            op(1, 1, 0, 0, 0, 0, "R5 unbounded load", 0, 1, 1, 0, 0, 0, 0);
        #1;
        check("R5 unbounded count", int'(lu_b), 8);
        check("R5 unbounded never full", int'(lf_b), 0);
        op(1, 0, 1, 0, 0, 0, "R7 alt second store", 0, 1, 3, 3'b011, 1, 2, 0);
        #1;
        check("R5 alt sq_full", int'(sf_b), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        t_main_a();
        t_alt_b();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule